// File: doc/BRIEF.md
# Page Access Permission Checker

This purely combinational block takes the protection bits gathered by a page walk and the attributes of the access that started the walk, and judges whether that access may proceed. Its inputs are the effective user, writable and no-execute bits of the page, the kind of access (data read, data write or instruction fetch), the privilege context of the requester and three control flags: write protection, supervisor fetch protection from user pages, and no-execute enable.

It has two outputs. The first is a protection fault flag. The second is the set of rights (read, write, execute) that a translation cache may store next to the mapping. In supervisor mode, user pages are judged by one of two rule sets, chosen by whether supervisor data access to user pages is blocked. Read-only pages stop supervisor writes only while write protection is enabled.

Top module: `perm_check`

## Requirements
- R1: `acc_kind` encodes 0 = data read, 1 = data write, 2 = instruction fetch, and 3 is treated as a data read. `priv_ctx` encodes 0 = user, 1 = supervisor with user-data blocking, 2 = supervisor without it, and 3 is treated as 2.
- R2: The page's no-execute bit takes effect only while `nxe_on` is 1. An instruction fetch from a page whose effective no-execute bit is set faults in every context.
- R3: In user context, any access to a page whose user bit is 0 faults.
- R4: In user context, a write to a page whose writable bit is 0 faults.
- R5: In context 1, a data read or write to a page whose user bit is 1 faults. A fetch in context 1 is not faulted by this rule.
- R6: In contexts 1, 2 and 3, a fetch from a page whose user bit is 1 faults exactly when `smep_on` is 1.
- R7: In contexts 1, 2 and 3, a write to a page whose writable bit is 0 faults when `wp_on` is 1 and is allowed when `wp_on` is 0.
- R8: `grant_rd` is always 1. `grant_ex` is 1 exactly when the effective no-execute bit is 0.
- R9: `grant_wr` is 1 when the writable bit is 1, or when the context is not user and `wp_on` is 0. Otherwise it is 0.
- R10: In every other case `prot_fault` is 0. The outputs follow the present inputs with no clock or state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pg_user | input | 1 | Effective user-accessible bit of the page |
| pg_rw | input | 1 | Effective writable bit of the page |
| pg_nx | input | 1 | No-execute bit of the page |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| priv_ctx | input | 2 | Context: 0 user, 1 supervisor blocking user data, 2/3 plain supervisor |
| wp_on | input | 1 | Write protection for supervisor writes |
| smep_on | input | 1 | Blocks supervisor fetches from user pages |
| nxe_on | input | 1 | Enables the no-execute bit |
| prot_fault | output | 1 | Access violates protection |
| grant_rd | output | 1 | Read right for the cache entry |
| grant_wr | output | 1 | Write right for the cache entry |
| grant_ex | output | 1 | Execute right for the cache entry |

## Verification
The stimulus first uses hand-picked patterns aimed at one rule each. These show whether each context applies its own rule and ignores the others'. Examples: a supervisor fetch from a user page with and without fetch protection, a supervisor write to a read-only page with and without write protection, and a no-execute page with the enable off. Next comes an exhaustive sweep of all 1024 input combinations, including the reserved access and context codes. The sweep separates rules that overlap, such as a data access in context 1 that must also meet the plain supervisor write rule. Every applied pattern is compared with a behavioural reference model on every clock.

// File: rtl/perm_pkg.sv
package perm_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CTX_USER     = 2'd0,
    CTX_SUP_BLK  = 2'd1,
    CTX_SUP      = 2'd2,
    CTX_SUP_RSVD = 2'd3
  } priv_ctx_e;

  typedef struct packed {
    logic is_read;
    logic is_write;
    logic is_fetch;
  } acc_dec_t;

  typedef struct packed {
    logic user;
    logic sup_blk;
    logic sup_any;
  } ctx_dec_t;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
  } rights_t;

endpackage

// File: rtl/perm_decode.sv
module perm_decode
  import perm_pkg::*;
(
  input  logic [1:0] acc_kind,
  input  logic [1:0] priv_ctx,
  input  logic       pg_nx,
  input  logic       nxe_on,
  output acc_dec_t   acc_dec,
  output ctx_dec_t   ctx_dec,
  output logic       nx_eff
);

  always_comb begin
    acc_dec = '0;
    unique case (acc_kind)
      ACC_WRITE: acc_dec.is_write = 1'b1;
      ACC_FETCH: acc_dec.is_fetch = 1'b1;
      default:   acc_dec.is_read  = 1'b1;
    endcase
  end

  always_comb begin
    ctx_dec = '0;
    unique case (priv_ctx)
      CTX_USER: ctx_dec.user = 1'b1;
      CTX_SUP_BLK: begin
        ctx_dec.sup_blk = 1'b1;
        ctx_dec.sup_any = 1'b1;
      end
      default: ctx_dec.sup_any = 1'b1;
    endcase
  end

  assign nx_eff = pg_nx & nxe_on;

endmodule

// File: rtl/perm_fault_eval.sv
module perm_fault_eval
  import perm_pkg::*;
(
  input  acc_dec_t acc_dec,
  input  ctx_dec_t ctx_dec,
  input  logic     pg_user,
  input  logic     pg_rw,
  input  logic     nx_eff,
  input  logic     wp_on,
  input  logic     smep_on,
  output logic     fault
);

  logic flt_exec;
  logic flt_user_ctx;
  logic flt_blk_data;
  logic flt_sup_fetch;
  logic flt_sup_write;

  always_comb begin
    flt_exec      = acc_dec.is_fetch & nx_eff;
    flt_user_ctx  = ctx_dec.user &
                    (~pg_user | (acc_dec.is_write & ~pg_rw));
    flt_blk_data  = ctx_dec.sup_blk & ~acc_dec.is_fetch & pg_user;
    flt_sup_fetch = ctx_dec.sup_any & acc_dec.is_fetch & pg_user & smep_on;
    flt_sup_write = ctx_dec.sup_any & acc_dec.is_write & ~pg_rw & wp_on;
    fault = flt_exec | flt_user_ctx | flt_blk_data |
            flt_sup_fetch | flt_sup_write;
  end

endmodule

// File: rtl/perm_rights.sv
module perm_rights
  import perm_pkg::*;
(
  input  ctx_dec_t ctx_dec,
  input  logic     pg_rw,
  input  logic     nx_eff,
  input  logic     wp_on,
  output rights_t  rights
);

  always_comb begin
    rights.rd = 1'b1;
    rights.wr = pg_rw | (ctx_dec.sup_any & ~wp_on);
    rights.ex = ~nx_eff;
  end

endmodule

// File: rtl/perm_check.sv
module perm_check
  import perm_pkg::*;
(
  input  logic       pg_user,
  input  logic       pg_rw,
  input  logic       pg_nx,
  input  logic [1:0] acc_kind,
  input  logic [1:0] priv_ctx,
  input  logic       wp_on,
  input  logic       smep_on,
  input  logic       nxe_on,
  output logic       prot_fault,
  output logic       grant_rd,
  output logic       grant_wr,
  output logic       grant_ex
);

  acc_dec_t acc_dec;
  ctx_dec_t ctx_dec;
  logic     nx_eff;
  rights_t  rights;

  perm_decode u_decode (
    .acc_kind (acc_kind),
    .priv_ctx (priv_ctx),
    .pg_nx    (pg_nx),
    .nxe_on   (nxe_on),
    .acc_dec  (acc_dec),
    .ctx_dec  (ctx_dec),
    .nx_eff   (nx_eff)
  );

  perm_fault_eval u_fault (
    .acc_dec (acc_dec),
    .ctx_dec (ctx_dec),
    .pg_user (pg_user),
    .pg_rw   (pg_rw),
    .nx_eff  (nx_eff),
    .wp_on   (wp_on),
    .smep_on (smep_on),
    .fault   (prot_fault)
  );

  perm_rights u_rights (
    .ctx_dec (ctx_dec),
    .pg_rw   (pg_rw),
    .nx_eff  (nx_eff),
    .wp_on   (wp_on),
    .rights  (rights)
  );

  assign grant_rd = rights.rd;
  assign grant_wr = rights.wr;
  assign grant_ex = rights.ex;

endmodule

// File: rtl/perm_check_sva.sv
module perm_check_sva (
  input logic       pg_user,
  input logic       pg_rw,
  input logic       pg_nx,
  input logic [1:0] acc_kind,
  input logic [1:0] priv_ctx,
  input logic       wp_on,
  input logic       smep_on,
  input logic       nxe_on,
  input logic       prot_fault,
  input logic       grant_rd,
  input logic       grant_wr,
  input logic       grant_ex
);

  always_comb begin
    // R2
    nx_fetch_chk: assert (!(acc_kind == 2'd2 && pg_nx && nxe_on) || prot_fault);
    // R3
    user_page_chk: assert (!(priv_ctx == 2'd0 && !pg_user) || prot_fault);
    // R4
    user_write_chk: assert (!(priv_ctx == 2'd0 && acc_kind == 2'd1 && !pg_rw) || prot_fault);
    // R5
    blk_data_chk: assert (!(priv_ctx == 2'd1 && acc_kind != 2'd2 && pg_user) || prot_fault);
    // R6
    sup_fetch_chk: assert (!(priv_ctx != 2'd0 && acc_kind == 2'd2 && pg_user && smep_on) || prot_fault);
    // R7
    sup_wp_chk: assert (!(priv_ctx != 2'd0 && acc_kind == 2'd1 && !pg_rw && wp_on) || prot_fault);
    // R8
    read_grant_chk: assert (grant_rd);
    // R8
    exec_grant_chk: assert (!(pg_nx && nxe_on) || !grant_ex);
    // R9
    write_grant_chk: assert (!pg_rw || grant_wr);
    // R10
    user_ok_chk: assert (!(priv_ctx == 2'd0 && pg_user && pg_rw && !pg_nx) || !prot_fault);
  end

endmodule

bind perm_check perm_check_sva u_sva (
  .pg_user    (pg_user),
  .pg_rw      (pg_rw),
  .pg_nx      (pg_nx),
  .acc_kind   (acc_kind),
  .priv_ctx   (priv_ctx),
  .wp_on      (wp_on),
  .smep_on    (smep_on),
  .nxe_on     (nxe_on),
  .prot_fault (prot_fault),
  .grant_rd   (grant_rd),
  .grant_wr   (grant_wr),
  .grant_ex   (grant_ex)
);

// File: tb/sim_perm_check.sv
module sim_perm_check;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk;
  logic rst_n;

  logic       pg_user, pg_rw, pg_nx;
  logic [1:0] acc_kind, priv_ctx;
  logic       wp_on, smep_on, nxe_on;
  logic       prot_fault, grant_rd, grant_wr, grant_ex;

  int checks;
  int failures;
  bit done;

  perm_check u0 (
    .pg_user    (pg_user),
    .pg_rw      (pg_rw),
    .pg_nx      (pg_nx),
    .acc_kind   (acc_kind),
    .priv_ctx   (priv_ctx),
    .wp_on      (wp_on),
    .smep_on    (smep_on),
    .nxe_on     (nxe_on),
    .prot_fault (prot_fault),
    .grant_rd   (grant_rd),
    .grant_wr   (grant_wr),
    .grant_ex   (grant_ex)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Reference model: returns {fault, rd, wr, ex}
  function automatic logic [3:0] ref_model(
    input logic u, input logic rw, input logic nx,
    input int acc, input int ctx,
    input logic wp, input logic smep, input logic nxe);
    bit nxe_eff, fetch, write, sup, flt, wr;
    nxe_eff = nx && nxe;
    fetch = (acc == 2);
    write = (acc == 1);
    sup = (ctx != 0);
    flt = 0;
    if (fetch && nxe_eff) flt = 1;
    if (!sup) begin
      if (!u) flt = 1;
      if (write && !rw) flt = 1;
    end else begin
      if (ctx == 1 && !fetch && u) flt = 1;
      if (fetch && u && smep) flt = 1;
      if (write && !rw && wp) flt = 1;
    end
    wr = rw || (sup && !wp);
    return {flt, 1'b1, wr, !nxe_eff};
  endfunction

  task automatic apply_chk(
    input logic u, input logic rw, input logic nx,
    input int acc, input int ctx,
    input logic wp, input logic smep, input logic nxe,
    input string tag);
    logic [3:0] exp_v;
    logic [3:0] act_v;
    @(posedge clk);
    #1;
    pg_user = u; pg_rw = rw; pg_nx = nx;
    acc_kind = 2'(acc); priv_ctx = 2'(ctx);
    wp_on = wp; smep_on = smep; nxe_on = nxe;
    @(negedge clk);
    exp_v = ref_model(u, rw, nx, acc, ctx, wp, smep, nxe);
    act_v = {prot_fault, grant_rd, grant_wr, grant_ex};
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s u=%0d rw=%0d nx=%0d acc=%0d ctx=%0d wp=%0d smep=%0d nxe=%0d actual=%b expected=%b",
               tag, u, rw, nx, acc, ctx, wp, smep, nxe, act_v, exp_v);
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 0;
    rst_n = 1'b0;
    pg_user = 0; pg_rw = 0; pg_nx = 0;
    acc_kind = 0; priv_ctx = 0;
    wp_on = 0; smep_on = 0; nxe_on = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // R3 idle pattern: user read of supervisor page
    apply_chk(0, 0, 0, 0, 0, 0, 0, 0, "R3");
    apply_chk(1, 1, 0, 0, 0, 0, 0, 0, "R10");
    // R4
    apply_chk(1, 0, 0, 1, 0, 1, 0, 0, "R4");
    apply_chk(1, 1, 0, 1, 0, 1, 0, 0, "R10");
    // R2: nx ignored without enable, honoured with it
    apply_chk(1, 1, 1, 2, 0, 0, 0, 0, "R2");
    apply_chk(1, 1, 1, 2, 0, 0, 0, 1, "R2");
    apply_chk(0, 1, 1, 2, 2, 0, 0, 1, "R2");
    // R5
    apply_chk(1, 1, 0, 0, 1, 0, 0, 0, "R5");
    apply_chk(1, 1, 0, 2, 1, 0, 0, 0, "R5");
    // R6
    apply_chk(1, 1, 0, 2, 2, 0, 0, 0, "R6");
    apply_chk(1, 1, 0, 2, 2, 0, 1, 0, "R6");
    apply_chk(1, 1, 0, 2, 1, 0, 1, 0, "R6");
    // R7 / R9
    apply_chk(0, 0, 0, 1, 2, 0, 0, 0, "R7");
    apply_chk(0, 0, 0, 1, 2, 1, 0, 0, "R7");
    apply_chk(0, 0, 0, 1, 1, 1, 0, 0, "R9");
    // R1 reserved codes
    apply_chk(0, 0, 0, 3, 2, 1, 0, 0, "R1");
    apply_chk(1, 1, 0, 2, 3, 0, 1, 0, "R1");
    // R8
    apply_chk(0, 1, 1, 0, 2, 0, 0, 1, "R8");

    // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 1024; v++) begin
      apply_chk(v[0], v[1], v[2], int'(v[4:3]), int'(v[6:5]),
                v[7], v[8], v[9], "R1_to_R10_sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule